// File: doc/BRIEF.md
# Programmable Cellular Automaton Pattern Generator

This block produces a stream of 32-bit pseudo-random patterns from a one-dimensional binary cellular automaton. Its 32 cells form a closed ring. On each step every cell takes a new value at the same time. That value is a bit of an 8-bit rule, and the bit is chosen by the cell's own value together with the values of its two adjacent cells. Software or a controller can load any of the 256 elementary rules. After reset the rule is 30, which gives chaotic output.

To use the block, a controller writes a starting pattern with a one-cycle load strobe. It can change the rule with a separate one-cycle strobe. It then raises the step request once for each new pattern it wants. The current ring state is always driven on the output, straight from the register.

Top module: `ring_automaton_prng`

## Requirements
- R1: When the synchronous active-low reset is applied at a rising clock edge, the ring state becomes 32'h0000_0001 (only cell 0 set) and the rule becomes 30 (8'h1E). The output shows that state from the next edge on.
- R2: When `seed_load_i` is high at a rising edge, the ring state takes the value of `seed_i`, and `pattern_o` shows that value after the edge.
- R3: When `step_i` is high and `seed_load_i` is low at an edge, every cell i is updated in that one edge. Its new value is bit k of the rule, where k = {cell i+1, cell i, cell i-1} and the bit from cell i+1 is the most significant.
- R4: The ring wraps around at both ends. Cell 31 uses cell 0 as its i+1 neighbour, and cell 0 uses cell 31 as its i-1 neighbour. As a result, rule 8'hF0 rotates the pattern one place toward bit 0, and rule 8'hAA rotates it one place toward bit 31.
- R5: When neither `seed_load_i` nor `step_i` is high at an edge, the ring state does not change.
- R6: When `seed_load_i` and `step_i` are both high at the same edge, the load wins and the state becomes `seed_i`.
- R7: When `rule_load_i` is high at an edge, the rule register takes `rule_i`. A step at that same edge still uses the previous rule, and steps at later edges use the new rule.
- R8: A rule load with no pattern load and no step leaves `pattern_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_i | input | 32 | Starting pattern to load |
| seed_load_i | input | 1 | Load strobe for `seed_i` |
| step_i | input | 1 | Request to advance the automaton by one generation |
| rule_i | input | 8 | New update rule |
| rule_load_i | input | 1 | Load strobe for `rule_i` |
| pattern_o | output | 32 | Current ring state |

## Verification
The output is the state register itself. A wrong cell value therefore shows on `pattern_o` at the very edge where it is written. On the following step it spreads one cell further in each direction, so the bench compares the output against a behavioural ring model after every edge. A rule register with the wrong value does not show until the next step. For that reason every rule load is followed at once by at least one step. The single-bit rotation rules make an error in the wrap-around or in the order of the neighbours visible as a bit in the wrong place.

// File: rtl/ca_ring_pkg.sv
package ca_ring_pkg;
    typedef enum logic [1:0] {
        CA_HOLD = 2'd0,
        CA_SEED = 2'd1,
        CA_STEP = 2'd2
    } ca_act_e;
endpackage

// File: rtl/ca_cell.sv
module ca_cell #(
    parameter int HOOD_W = 3,
    localparam int RULE_W = 2 ** HOOD_W
) (
    input  logic [HOOD_W-1:0] hood_i,
    input  logic [RULE_W-1:0] rule_i,
    output logic              next_o
);
    // Each cell looks up its neighbourhood code in the rule.
    always_comb begin
        next_o = rule_i[hood_i];
    end
endmodule

// File: rtl/ca_ring_step.sv
module ca_ring_step #(
    parameter int CELLS  = 32,
    parameter int RULE_W = 8
) (
    input  logic [CELLS-1:0]  cur_i,
    input  logic [RULE_W-1:0] rule_i,
    output logic [CELLS-1:0]  nxt_o
);
    for (genvar g = 0; g < CELLS; g++) begin : g_cell
        localparam int UP = (g == CELLS - 1) ? 0 : g + 1;
        localparam int DN = (g == 0) ? CELLS - 1 : g - 1;
        logic [2:0] hood;
        always_comb begin
            hood = {cur_i[UP], cur_i[g], cur_i[DN]};
        end
        ca_cell #(.HOOD_W(3)) u_cell (
            .hood_i (hood),
            .rule_i (rule_i),
            .next_o (nxt_o[g])
        );
    end
endmodule

// File: rtl/ca_ctrl_sel.sv
module ca_ctrl_sel
    import ca_ring_pkg::*;
(
    input  logic    seed_load_i,
    input  logic    step_i,
    output ca_act_e act_o
);
    // A pattern load takes priority over a step.
    always_comb begin
        if (seed_load_i)  act_o = CA_SEED;
        else if (step_i)  act_o = CA_STEP;
        else              act_o = CA_HOLD;
    end
endmodule

// File: rtl/ring_automaton_prng.sv
module ring_automaton_prng
    import ca_ring_pkg::*;
#(
    parameter int          CELLS      = 32,
    parameter int          RULE_W     = 8,
    parameter logic [7:0]  RULE_RESET = 8'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CELLS-1:0]  seed_i,
    input  logic              seed_load_i,
    input  logic              step_i,
    input  logic [RULE_W-1:0] rule_i,
    input  logic              rule_load_i,
    output logic [CELLS-1:0]  pattern_o
);
    localparam logic [CELLS-1:0] CELLS_RESET = {{(CELLS-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CELLS-1:0]  cells;
        logic [RULE_W-1:0] rule;
    } ca_regs_t;

    ca_regs_t         regs_d, regs_q;
    ca_act_e          act;
    logic [CELLS-1:0] ring_nxt;

    ca_ctrl_sel u_sel (
        .seed_load_i (seed_load_i),
        .step_i      (step_i),
        .act_o       (act)
    );

    ca_ring_step #(.CELLS(CELLS), .RULE_W(RULE_W)) u_step (
        .cur_i  (regs_q.cells),
        .rule_i (regs_q.rule),
        .nxt_o  (ring_nxt)
    );

    always_comb begin
        regs_d = regs_q;
        case (act)
            CA_SEED: regs_d.cells = seed_i;
            CA_STEP: regs_d.cells = ring_nxt;
            default: regs_d.cells = regs_q.cells;
        endcase
        if (rule_load_i) regs_d.rule = rule_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.cells <= CELLS_RESET;
            regs_q.rule  <= RULE_RESET[RULE_W-1:0];
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pattern_o = regs_q.cells;
endmodule

// File: rtl/ring_automaton_prng_chk.sv
module ring_automaton_prng_chk #(
    parameter int CELLS  = 32,
    parameter int RULE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CELLS-1:0]  seed_i,
    input logic              seed_load_i,
    input logic              step_i,
    input logic [RULE_W-1:0] rule_i,
    input logic              rule_load_i,
    input logic [RULE_W-1:0] rule_q,
    input logic [CELLS-1:0]  pattern_o
);
    AST_RESET_STATE: assert property (@(posedge clk) $rose(rst_n) |-> (pattern_o == {{(CELLS-1){1'b0}}, 1'b1} && rule_q == 8'h1E)); // R1
    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n) seed_load_i |=> pattern_o == $past(seed_i)); // R2
    AST_CELL0_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (step_i && !seed_load_i) |=> pattern_o[0] == $past(rule_q[{pattern_o[1], pattern_o[0], pattern_o[CELLS-1]}])); // R4
    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (step_i && !seed_load_i) |=> pattern_o[CELLS-1] == $past(rule_q[{pattern_o[0], pattern_o[CELLS-1], pattern_o[CELLS-2]}])); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!seed_load_i && !step_i) |=> $stable(pattern_o)); // R5
    AST_RULE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) rule_load_i |=> rule_q == $past(rule_i)); // R7
    AST_RULE_KEEP: assert property (@(posedge clk) disable iff (!rst_n) !rule_load_i |=> $stable(rule_q)); // R7
endmodule

bind ring_automaton_prng ring_automaton_prng_chk #(.CELLS(CELLS), .RULE_W(RULE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seed_i      (seed_i),
    .seed_load_i (seed_load_i),
    .step_i      (step_i),
    .rule_i      (rule_i),
    .rule_load_i (rule_load_i),
    .rule_q      (regs_q.rule),
    .pattern_o   (pattern_o)
);

// File: tb/ring_automaton_prng_bench.sv
module ring_automaton_prng_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] seed_i = '0;
    logic        seed_load_i = 1'b0;
    logic        step_i = 1'b0;
    logic [7:0]  rule_i = '0;
    logic        rule_load_i = 1'b0;
    logic [31:0] pattern_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0]  m_rule;
    logic [31:0] m_state;

    always #10 clk = ~clk;

    ring_automaton_prng u_ring_automaton_prng (
        .clk (clk), .rst_n (rst_n), .seed_i (seed_i), .seed_load_i (seed_load_i),
        .step_i (step_i), .rule_i (rule_i), .rule_load_i (rule_load_i),
        .pattern_o (pattern_o)
    );

    typedef struct packed {
        logic [31:0] seed;
        logic [7:0]  rule;
        logic [3:0]  steps;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0001_0000, 8'd30,  4'd6},
        '{32'h0001_0000, 8'd90,  4'd7},
        '{32'h0000_8000, 8'd110, 4'd8},
        '{32'hDEAD_BEEF, 8'd30,  4'd5},
        '{32'h8000_0001, 8'd90,  4'd4},
        '{32'hFFFF_FFFF, 8'd150, 4'd3},
        '{32'h1234_5678, 8'd184, 4'd5},
        '{32'h0000_0000, 8'd1,   4'd3}
    };

    function automatic logic [31:0] model_step(logic [31:0] s, logic [7:0] r);
        logic [31:0] n;
        for (int i = 0; i < 32; i++) begin
            n[i] = r[{s[(i + 1) % 32], s[i], s[(i + 31) % 32]}];
        end
        return n;
    endfunction

    task automatic check(string req, logic [31:0] exp);
        n_vec++;
        if (pattern_o !== exp) begin
            n_bad++;
            $display("FAIL %s: pattern_o=%h expected=%h", req, pattern_o, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, release, sample.
    task automatic cycle(logic ld, logic [31:0] sd, logic st, logic rl, logic [7:0] rv);
        @(negedge clk);
        seed_load_i = ld; seed_i = sd; step_i = st; rule_load_i = rl; rule_i = rv;
        @(negedge clk);
        seed_load_i = 1'b0; step_i = 1'b0; rule_load_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset pattern", 32'h0000_0001);
        m_state = 32'h0000_0001;
        m_rule  = 8'h1E;
        cycle(1'b0, '0, 1'b1, 1'b0, '0);
        m_state = model_step(m_state, m_rule);
        check("R1 default rule 30", m_state);

        for (int v = 0; v < 8; v++) begin
            cycle(1'b0, '0, 1'b0, 1'b1, VECS[v].rule);
            m_rule = VECS[v].rule;
            cycle(1'b1, VECS[v].seed, 1'b0, 1'b0, '0);
            m_state = VECS[v].seed;
            check("R2 seed load", m_state);
            for (int k = 0; k < int'(VECS[v].steps); k++) begin
                cycle(1'b0, '0, 1'b1, 1'b0, '0);
                m_state = model_step(m_state, m_rule);
                check("R3 step", m_state);
            end
        end

        // R4 wrap both ways with rotation rules
        cycle(1'b0, '0, 1'b0, 1'b1, 8'hF0);
        cycle(1'b1, 32'h0000_0001, 1'b0, 1'b0, '0);
        cycle(1'b0, '0, 1'b1, 1'b0, '0);
        check("R4 cell0 to cell31", 32'h8000_0000);
        cycle(1'b0, '0, 1'b0, 1'b1, 8'hAA);
        cycle(1'b0, '0, 1'b1, 1'b0, '0);
        check("R4 cell31 to cell0", 32'h0000_0001);
        cycle(1'b0, '0, 1'b1, 1'b0, '0);
        check("R4 rotate up", 32'h0000_0002);

        // R5 hold
        repeat (4) @(negedge clk);
        check("R5 idle hold", 32'h0000_0002);

        // R6 priority
        cycle(1'b1, 32'hA5A5_0F0F, 1'b1, 1'b0, '0);
        check("R6 load beats step", 32'hA5A5_0F0F);

        // R7 step with simultaneous rule load uses old rule (8'hAA)
        m_state = 32'hA5A5_0F0F;
        cycle(1'b0, '0, 1'b1, 1'b1, 8'd30);
        m_state = model_step(m_state, 8'hAA);
        check("R7 same-edge old rule", m_state);
        cycle(1'b0, '0, 1'b1, 1'b0, '0);
        m_state = model_step(m_state, 8'd30);
        check("R7 new rule next step", m_state);

        // R8 rule load alone leaves pattern unchanged
        cycle(1'b0, '0, 1'b0, 1'b1, 8'd90);
        check("R8 rule load no pattern change", m_state);
        cycle(1'b0, '0, 1'b1, 1'b0, '0);
        m_state = model_step(m_state, 8'd90);
        check("R7 rule 90 applied", m_state);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset again", 32'h0000_0001);
        cycle(1'b0, '0, 1'b1, 1'b0, '0);
        check("R1 rule restored", model_step(32'h0000_0001, 8'h1E));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule